// File: doc/BRIEF.md
# Paged Instruction Cache Controller

This block manages a small instruction cache that holds one page of a larger program store. The cache has 32 words of 16 bits. The program store holds 128 such words, split into 4 pages. Each page is exactly the size of the cache, so every word of a page has a fixed cache slot. The controller records which page is resident in a 2-bit tag. It also owns the core's word pointer inside that page.

The core fetches through the controller. It can ask for the next sequential word, or it can present the 7-bit target of a branch, call or return. In a target, bits 6:5 name the page and bits 4:0 name the word. A target inside the resident page is served from the cache at once. A target in another page raises a stall. The controller then streams the whole new page out of the synchronous backing store into the cache, slot 0 first. Once the copy is done it updates the tag and resumes at the target word. Sequential fetch never leaves the page: stepping past word 31 wraps to word 0 and leaves the tag unchanged.

At reset the controller fills page 0 before it lets the core run.

Top module: `pgcache_ctrl`

## Requirements
- R1: While reset is held, `busy` is 1 and `instr_valid` is 0. After reset is released, `busy` stays 1 through the first 32 rising edges and falls at the 33rd. Then `pc_word` is 0, `page_tag` is 0, and `instr_data` shows backing word 0.
- R2: During a reload of page P, the controller issues exactly 32 reads, one per cycle. `mem_rd_addr` is P*32 + i for i = 0, 1, ..., 31, in ascending order.
- R3: After a reload of page P, the cache slot i returns backing word P*32 + i. `instr_data` always shows the slot selected by `pc_word`.
- R4: When `jump_valid` is high, `busy` is 0, and `jump_target[6:5]` equals `page_tag`, then after the next edge `pc_word` equals `jump_target[4:0]` and `busy` stays 0.
- R5: When `jump_valid` is high, `busy` is 0, and `jump_target[6:5]` differs from `page_tag`, then `busy` rises at the next edge and stays high for 33 cycles. After that, `pc_word` equals the target's low 5 bits.
- R6: `advance` with `busy` 0 adds 1 to `pc_word`. From word 31 it wraps to 0, with no reload and no change to `page_tag`.
- R7: While `busy` is 1, `instr_valid` is 0, and both `jump_valid` and `advance` are ignored.
- R8: If `jump_valid` and `advance` are high in the same cycle, the jump wins.
- R9: `page_tag` keeps the old page for the whole reload. It takes the new page at the same edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| jump_valid | input | 1 | Control-transfer target is present |
| jump_target | input | 7 | Target: bits 6:5 page, bits 4:0 word |
| advance | input | 1 | Step to the next sequential word |
| instr_data | output | 16 | Cache word at the current pointer |
| instr_valid | output | 1 | `instr_data` may be consumed |
| pc_word | output | 5 | Current word pointer inside the page |
| page_tag | output | 2 | Resident page number |
| busy | output | 1 | Reload in progress, core stalled |
| mem_rd_en | output | 1 | Backing-store read strobe |
| mem_rd_addr | output | 7 | Backing-store word address |
| mem_rd_data | input | 16 | Backing-store data, one cycle after the strobe |

## Verification
A hit or a sequential step shows in `pc_word` and `instr_data` one edge after the request. A miss raises `busy` at the edge that accepts the target. `busy` then falls 33 edges later: 32 read cycles, plus one cycle because the backing store returns data one cycle after the read. At that same edge the tag and the pointer change. The bench drives inputs on the falling edge and samples one falling edge later, so each result is read just after the edge that produces it. Reload length is measured by counting falling edges while `busy` is high, and the issued read addresses are logged on rising edges and compared in order.

// File: rtl/icc_pkg.sv
package icc_pkg;
    localparam int WORD_W    = 16;
    localparam int IDX_BITS  = 5;
    localparam int PAGE_BITS = 2;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_RUN,
        FILL_DRAIN
    } fill_phase_e;
endpackage

// File: rtl/icc_store.sv
module icc_store #(
    parameter int WORD_W   = icc_pkg::WORD_W,
    parameter int IDX_BITS = icc_pkg::IDX_BITS
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [WORD_W-1:0]   rd_data
);
    localparam int ENTRIES = 1 << IDX_BITS;

    logic [WORD_W-1:0] slot_q [ENTRIES];
    logic [WORD_W-1:0] slot_d [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_idx == IDX_BITS'(g))) begin
                slot_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            slot_q[g] <= slot_d[g];
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/icc_fill_seq.sv
module icc_fill_seq #(
    parameter int IDX_BITS  = icc_pkg::IDX_BITS,
    parameter int PAGE_BITS = icc_pkg::PAGE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [PAGE_BITS-1:0]          start_page,
    output logic                          rd_en,
    output logic [PAGE_BITS+IDX_BITS-1:0] rd_addr,
    output logic                          wr_en,
    output logic [IDX_BITS-1:0]           wr_idx,
    output logic                          done
);
    import icc_pkg::*;

    localparam logic [IDX_BITS-1:0] LAST_IDX = '1;

    typedef struct packed {
        fill_phase_e          phase;
        logic [IDX_BITS-1:0]  cnt;
        logic [PAGE_BITS-1:0] page;
        logic                 pend;
        logic [IDX_BITS-1:0]  widx;
    } fill_state_t;

    fill_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        unique case (st_q.phase)
            FILL_IDLE: begin
                if (start) begin
                    st_d.phase = FILL_RUN;
                    st_d.cnt   = '0;
                    st_d.page  = start_page;
                end
            end
            FILL_RUN: begin
                st_d.pend = 1'b1;
                st_d.widx = st_q.cnt;
                if (st_q.cnt == LAST_IDX) begin
                    st_d.phase = FILL_DRAIN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            FILL_DRAIN: begin
                st_d.phase = FILL_IDLE;
            end
            default: st_d.phase = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= FILL_RUN;
            st_q.cnt   <= '0;
            st_q.page  <= '0;
            st_q.pend  <= 1'b0;
            st_q.widx  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en   = (st_q.phase == FILL_RUN);
    assign rd_addr = {st_q.page, st_q.cnt};
    assign wr_en   = st_q.pend;
    assign wr_idx  = st_q.widx;
    assign done    = (st_q.phase == FILL_DRAIN);

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (wr_en && wr_idx == $past(rd_addr[IDX_BITS-1:0]))); // R3
    AST_READ_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_addr[IDX_BITS-1:0] == wr_idx + 1'b1)); // R2
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> $stable(rd_addr[PAGE_BITS+IDX_BITS-1:IDX_BITS])); // R2
endmodule

// File: rtl/pgcache_ctrl.sv
module pgcache_ctrl #(
    parameter int WORD_W    = icc_pkg::WORD_W,
    parameter int IDX_BITS  = icc_pkg::IDX_BITS,
    parameter int PAGE_BITS = icc_pkg::PAGE_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          jump_valid,
    input  logic [PAGE_BITS+IDX_BITS-1:0] jump_target,
    input  logic                          advance,
    output logic [WORD_W-1:0]             instr_data,
    output logic                          instr_valid,
    output logic [IDX_BITS-1:0]           pc_word,
    output logic [PAGE_BITS-1:0]          page_tag,
    output logic                          busy,
    output logic                          mem_rd_en,
    output logic [PAGE_BITS+IDX_BITS-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0]             mem_rd_data
);
    localparam int ADDR_W = PAGE_BITS + IDX_BITS;

    typedef struct packed {
        logic                 busy;
        logic [PAGE_BITS-1:0] tag;
        logic [PAGE_BITS-1:0] pend_page;
        logic [IDX_BITS-1:0]  resume;
        logic [IDX_BITS-1:0]  ptr;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;

    logic                 fill_start;
    logic                 fill_done;
    logic                 fill_wr_en;
    logic [IDX_BITS-1:0]  fill_wr_idx;
    logic [PAGE_BITS-1:0] tgt_page;
    logic [IDX_BITS-1:0]  tgt_word;

    assign tgt_page = jump_target[ADDR_W-1:IDX_BITS];
    assign tgt_word = jump_target[IDX_BITS-1:0];

    always_comb begin
        st_d       = st_q;
        fill_start = 1'b0;
        if (st_q.busy) begin
            if (fill_done) begin
                st_d.busy = 1'b0;
                st_d.tag  = st_q.pend_page;
                st_d.ptr  = st_q.resume;
            end
        end else if (jump_valid) begin
            if (tgt_page == st_q.tag) begin
                st_d.ptr = tgt_word;
            end else begin
                fill_start     = 1'b1;
                st_d.busy      = 1'b1;
                st_d.pend_page = tgt_page;
                st_d.resume    = tgt_word;
            end
        end else if (advance) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy      <= 1'b1;
            st_q.tag       <= '0;
            st_q.pend_page <= '0;
            st_q.resume    <= '0;
            st_q.ptr       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    icc_fill_seq #(
        .IDX_BITS  (IDX_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fill_start),
        .start_page (tgt_page),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .wr_en      (fill_wr_en),
        .wr_idx     (fill_wr_idx),
        .done       (fill_done)
    );

    icc_store #(
        .WORD_W   (WORD_W),
        .IDX_BITS (IDX_BITS)
    ) u_store (
        .clk     (clk),
        .wr_en   (fill_wr_en),
        .wr_idx  (fill_wr_idx),
        .wr_data (mem_rd_data),
        .rd_idx  (st_q.ptr),
        .rd_data (instr_data)
    );

    assign instr_valid = !st_q.busy;
    assign pc_word     = st_q.ptr;
    assign page_tag    = st_q.tag;
    assign busy        = st_q.busy;

    AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jump_valid && tgt_page == page_tag)
        |=> (!busy && pc_word == $past(tgt_word))); // R4
    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jump_valid && tgt_page != page_tag) |=> busy); // R5
    AST_WRAP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !jump_valid && advance && pc_word == '1)
        |=> (!busy && pc_word == '0 && $stable(page_tag))); // R6
    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fill_done) |=> (busy && $stable(pc_word) && $stable(page_tag))); // R7
    AST_FILL_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy); // R7
    AST_TAG_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_done) |=> (!busy && page_tag == $past(st_q.pend_page))); // R9
endmodule

// File: tb/pgcache_ctrl_tb.sv
module pgcache_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jump_valid = 1'b0;
    logic [6:0]  jump_target = '0;
    logic        advance = 1'b0;
    logic [15:0] instr_data;
    logic        instr_valid;
    logic [4:0]  pc_word;
    logic [1:0]  page_tag;
    logic        busy;
    logic        mem_rd_en;
    logic [6:0]  mem_rd_addr;
    logic [15:0] mem_rd_data = '0;

    logic [15:0] bmem [128];
    logic [6:0]  logv [64];
    int          nlog = 0;
    logic        rec_on = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    pgcache_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .jump_valid  (jump_valid),
        .jump_target (jump_target),
        .advance     (advance),
        .instr_data  (instr_data),
        .instr_valid (instr_valid),
        .pc_word     (pc_word),
        .page_tag    (page_tag),
        .busy        (busy),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= bmem[mem_rd_addr];
    end

    always @(posedge clk) begin
        if (rec_on && mem_rd_en) begin
            if (nlog < 64) logv[nlog] = mem_rd_addr;
            nlog = nlog + 1;
        end
    end

    function automatic logic [15:0] word_at(int a);
        return 16'(a * 16'h0301) ^ 16'hC35A;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", 32'(busy), 32'd1);
        check("R1", "valid in reset", 32'(instr_valid), 32'd0);
        rst_n = 1'b1;
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R1", "reset fill length", 32'(n), 32'd33);
        check("R1", "pc after reset", 32'(pc_word), 32'd0);
        check("R1", "tag after reset", 32'(page_tag), 32'd0);
        check("R1", "word 0 after reset", 32'(instr_data), 32'(word_at(0)));
    endtask

    task automatic t_hit(int w);
        int p;
        p = int'(page_tag);
        jump_valid = 1'b1;
        jump_target = {2'(p), 5'(w)};
        @(negedge clk);
        jump_valid = 1'b0;
        check("R4", "hit pc", 32'(pc_word), 32'(w));
        check("R4", "hit no stall", 32'(busy), 32'd0);
        check("R4", "hit data", 32'(instr_data), 32'(word_at(p * 32 + w)));
    endtask

    task automatic t_walk();
        int p;
        p = int'(page_tag);
        t_hit(0);
        for (int i = 1; i < 32; i++) begin
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            check("R6", "advance pc", 32'(pc_word), 32'(i));
            check("R3", "slot content", 32'(instr_data), 32'(word_at(p * 32 + i)));
        end
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        check("R6", "wrap pc", 32'(pc_word), 32'd0);
        check("R6", "wrap no reload", 32'(busy), 32'd0);
        check("R6", "wrap tag kept", 32'(page_tag), 32'(p));
        check("R3", "wrap data", 32'(instr_data), 32'(word_at(p * 32)));
    endtask

    task automatic t_miss(int p, int w);
        int n;
        int old_tag;
        old_tag = int'(page_tag);
        nlog = 0;
        rec_on = 1'b1;
        jump_valid = 1'b1;
        jump_target = {2'(p), 5'(w)};
        @(negedge clk);
        jump_valid = 1'b0;
        check("R5", "miss raises busy", 32'(busy), 32'd1);
        n = 0;
        while (busy && n < 100) begin
            n++;
            if (n >= 3 && n <= 6) begin
                jump_valid = 1'b1;
                jump_target = {2'(old_tag), 5'(w ^ 3)};
                advance = 1'b1;
            end else begin
                jump_valid = 1'b0;
                advance = 1'b0;
            end
            if (n == 5) check("R7", "valid low while busy", 32'(instr_valid), 32'd0);
            if (n == 10) check("R9", "tag old mid-fill", 32'(page_tag), 32'(old_tag));
            @(negedge clk);
        end
        jump_valid = 1'b0;
        advance = 1'b0;
        rec_on = 1'b0;
        check("R5", "miss stall length", 32'(n), 32'd33);
        check("R5", "resume pc", 32'(pc_word), 32'(w));
        check("R7", "stalled requests ignored", 32'(pc_word), 32'(w));
        check("R9", "tag after fill", 32'(page_tag), 32'(p));
        check("R3", "resume data", 32'(instr_data), 32'(word_at(p * 32 + w)));
        check("R2", "read count", 32'(nlog), 32'd32);
        for (int i = 0; i < 32; i++) begin
            if (i < nlog) check("R2", "read order", 32'(logv[i]), 32'(p * 32 + i));
        end
    endtask

    task automatic t_priority(int w);
        int p;
        p = int'(page_tag);
        jump_valid = 1'b1;
        advance = 1'b1;
        jump_target = {2'(p), 5'(w)};
        @(negedge clk);
        jump_valid = 1'b0;
        advance = 1'b0;
        check("R8", "jump beats advance", 32'(pc_word), 32'(w));
        check("R8", "no stall", 32'(busy), 32'd0);
    endtask

    initial begin
        for (int a = 0; a < 128; a++) bmem[a] = word_at(a);
        t_reset();
        t_hit(7);
        t_hit(31);
        t_walk();
        t_miss(2, 9);
        t_walk();
        t_priority(12);
        t_miss(3, 31);
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        check("R6", "wrap after miss", 32'(pc_word), 32'd0);
        check("R6", "tag after wrap", 32'(page_tag), 32'd3);
        t_miss(0, 5);
        t_hit(20);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule